// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a memory-mapped watchdog timer. Software arms it, picks an interval, and then has to send a keyed reload command before each interval runs out. If a reload does not arrive in time, the block either pulses a system reset for one cycle or raises a sticky interrupt. The configuration register selects which of the two happens. The time base comes from a `tick` input that pulses once every half second. A 4-bit code picks the interval from a nonlinear table that runs from half a second to sixteen seconds.

Three registers sit on a simple bus with address, write data, write strobe, read strobe and combinational read data. The three are: control at 0x10, configuration at 0x14 and mode at 0x18. A write to configuration or mode has an effect only when its upper halfword carries the key 0x16AA. A reload happens only when the control write carries the reload pattern. Any other write to those registers leaves every state in the block unchanged.

Top module: `guard_timer`

## Requirements
- R1: After reset the watchdog is disabled. Reads of mode (0x18) and configuration (0x14) return 0, and `sys_rst_o` and `irq_o` are low.
- R2: A write to 0x14 or 0x18 whose data bits 31:16 equal 0x16AA updates the register. On read-back, configuration shows the action in bits 1:0. Mode shows the enable in bit 0 and the timeout code in bits 7:4. All other bits, the key field included, read as 0.
- R3: A write to 0x14 or 0x18 whose bits 31:16 differ from 0x16AA is ignored. The register keeps its old value.
- R4: A write to 0x10 reloads the counter only when bit 0 is 1 and bits 12:1 equal 0xA57, which is low halfword 0x14AF. Any other control write is ignored and the count continues.
- R5: The number of ticks from a reload to expiry follows the code:
  - code 0 gives 1 tick;
  - codes 1 to 6 give twice the code;
  - codes 7, 8, 9, 0xA and 0xB give 16, 20, 24, 28 and 32 ticks;
  - codes 0xC to 0xF give 32 ticks.
- R6: While mode bit 0 is 0, ticks produce no reset and no interrupt. A keyed write that clears bit 0 stops the count.
- R7: With action 01, expiry drives `sys_rst_o` high for exactly one clock, in the cycle after the expiring tick. The counter then reloads, so the next expiry comes after a full interval.
- R8: With any action other than 01, expiry sets `irq_o` and never pulses `sys_rst_o`. `irq_o` stays high until a valid reload command clears it.
- R9: Writing a new code and then reloading restarts the count from the new interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Half-second time-base pulse, one clock wide |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid while rd_en is high |
| sys_rst_o | output | 1 | One-cycle system reset pulse on timeout |
| irq_o | output | 1 | Sticky timeout interrupt |

## Verification
A corrupted remaining count shows up as a reset or interrupt on the wrong tick. For that reason the bench counts ticks from each reload to the first pulse for every code class, and an error appears within one interval of at most 32 ticks. Wrong key or reload decoding shows either as a register read-back that changed when it should not have, or as an expiry that arrives early or late by the number of ticks the bad reload should or should not have restored. A stuck action register shows at once as a pulse on the wrong output, or as an interrupt that fails to stay set or to clear.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;
  localparam int CNT_W = 6;
  localparam logic [15:0] WR_KEY     = 16'h16AA;
  localparam logic [11:0] RELOAD_TAG = 12'hA57;
  localparam logic [1:0]  ACT_SYSRST = 2'b01;

  // Half-second ticks in the interval selected by a timeout code.
  function automatic logic [CNT_W-1:0] ticks_for_code(input logic [3:0] code);
    logic [CNT_W-1:0] c;
    c = {{(CNT_W-4){1'b0}}, code};
    if (code == 4'h0)       return CNT_W'(1);
    else if (code <= 4'h6)  return CNT_W'(c << 1);
    else if (code <= 4'hB)  return CNT_W'((c << 2) - CNT_W'(12));
    else                    return CNT_W'(32);
  endfunction
endpackage

// File: rtl/gt_regs.sv
module gt_regs
  import guard_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] CFG_OFS  = 8'h14,
  parameter logic [ADDR_W-1:0] MODE_OFS = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              mode_en,
  output logic [3:0]        mode_code,
  output logic [1:0]        act_sel,
  output logic              reload_cmd
);
  localparam int KEY_LSB = DATA_W - 16;

  logic key_ok;
  assign key_ok = (wr_data[DATA_W-1:KEY_LSB] == WR_KEY);
  assign reload_cmd = wr_en && (addr == CTRL_OFS) && wr_data[0] &&
                      (wr_data[12:1] == RELOAD_TAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_en   <= 1'b0;
      mode_code <= 4'h0;
      act_sel   <= 2'b00;
    end else if (wr_en && key_ok) begin
      if (addr == CFG_OFS) act_sel <= wr_data[1:0];
      if (addr == MODE_OFS) begin
        mode_en   <= wr_data[0];
        mode_code <= wr_data[7:4];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (addr == CFG_OFS) rd_data[1:0] = act_sel;
      if (addr == MODE_OFS) begin
        rd_data[7:4] = mode_code;
        rd_data[0]   = mode_en;
      end
    end
  end
endmodule

// File: rtl/gt_count.sv
module gt_count
  import guard_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic [3:0]       code,
  input  logic             reload_cmd,
  output logic             expire,
  output logic [CNT_W-1:0] remain
);
  logic [CNT_W-1:0] full;
  assign full   = ticks_for_code(code);
  assign expire = enable && tick && !reload_cmd && (remain == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   remain <= CNT_W'(1);
    else if (!enable || reload_cmd || expire) remain <= full;
    else if (tick)                remain <= remain - CNT_W'(1);
  end
endmodule

// File: rtl/gt_action.sv
module gt_action
  import guard_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  logic [1:0] act_sel,
  input  logic       reload_cmd,
  output logic       sys_rst_o,
  output logic       irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_rst_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      sys_rst_o <= expire && (act_sel == ACT_SYSRST);
      if (expire && (act_sel != ACT_SYSRST)) irq_o <= 1'b1;
      else if (reload_cmd)                   irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h10,
  parameter logic [ADDR_W-1:0] CFG_OFS  = 8'h14,
  parameter logic [ADDR_W-1:0] MODE_OFS = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              sys_rst_o,
  output logic              irq_o
);
  logic             mode_en;
  logic [3:0]       mode_code;
  logic [1:0]       act_sel;
  logic             reload_cmd;
  logic             expire;
  logic [CNT_W-1:0] remain;

  gt_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CTRL_OFS(CTRL_OFS), .CFG_OFS(CFG_OFS), .MODE_OFS(MODE_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .mode_en(mode_en), .mode_code(mode_code),
    .act_sel(act_sel), .reload_cmd(reload_cmd)
  );

  gt_count u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(mode_en), .code(mode_code),
    .reload_cmd(reload_cmd), .expire(expire), .remain(remain)
  );

  gt_action u_action (
    .clk(clk), .rst_n(rst_n), .expire(expire), .act_sel(act_sel),
    .reload_cmd(reload_cmd), .sys_rst_o(sys_rst_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk
  import guard_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] MODE_OFS = 8'h18
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              mode_en,
  input logic [3:0]        mode_code,
  input logic [1:0]        act_sel,
  input logic              reload_cmd,
  input logic              expire,
  input logic [CNT_W-1:0]  remain,
  input logic              sys_rst_o,
  input logic              irq_o
);
  // R7: the reset pulse lasts a single cycle
  a_r7_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |=> !sys_rst_o);

  // R7: an expiry with the reset action produces the pulse
  a_r7_rst_follows_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && act_sel == ACT_SYSRST) |=> sys_rst_o);

  // R6: a disabled watchdog produces no reset
  a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> !sys_rst_o);

  // R8: the interrupt holds until a valid reload
  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !reload_cmd) |=> irq_o);

  // R3: a mode write without the key leaves mode unchanged
  a_r3_mode_keyless_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == MODE_OFS && wr_data[DATA_W-1:DATA_W-16] != WR_KEY)
      |=> ($stable(mode_en) && $stable(mode_code)));

  // R5: the remaining count never leaves its legal range
  a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    (remain != '0) && (remain <= CNT_W'(32)));
endmodule

bind guard_timer guard_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_OFS(MODE_OFS)
) chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .mode_en(mode_en), .mode_code(mode_code), .act_sel(act_sel),
  .reload_cmd(reload_cmd), .expire(expire), .remain(remain),
  .sys_rst_o(sys_rst_o), .irq_o(irq_o)
);

// File: tb/guard_timer_test.sv
`timescale 1ns/1ps
module guard_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        sys_rst_o;
  logic        irq_o;

  int total = 0;
  int bad = 0;

  localparam logic [7:0]  A_CTRL = 8'h10, A_CFG = 8'h14, A_MODE = 8'h18;
  localparam logic [31:0] KEYV = 32'h16AA_0000;
  localparam logic [31:0] RELOAD = 32'h0000_14AF;

  // code, expected ticks to expiry
  localparam int NV = 9;
  localparam int VEC [NV][2] = '{
    '{0, 1}, '{1, 2}, '{4, 8}, '{6, 12}, '{7, 16},
    '{9, 24}, '{11, 32}, '{12, 32}, '{15, 32}
  };

  always #2.5 clk = ~clk;

  guard_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .sys_rst_o(sys_rst_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    rd_en = 1'b0;
  endtask

  // one tick pulse; returns right after the clock edge that consumed it
  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  // ticks until the reset pulse, up to limit; 0 when none
  task automatic ticks_to_rst(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      pulse_tick();
      if (sys_rst_o && n == 0) n = i;
      if (n != 0) break;
    end
  endtask

  task automatic arm(input logic [3:0] code, input logic [1:0] act);
    wr(A_CFG, KEYV | {30'b0, act});
    wr(A_MODE, KEYV | {24'b0, code, 4'b0001});
    wr(A_CTRL, RELOAD);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_MODE, d); check("R1 mode", d, 32'h0);
    rd(A_CFG, d);  check("R1 cfg", d, 32'h0);
    check("R1 outputs", {30'b0, sys_rst_o, irq_o}, 32'h0);
    ticks_to_rst(4, n); check("R1 disabled no reset", n, 0);

    // R2 keyed writes, read-back layout
    wr(A_CFG, KEYV | 32'h0000_FFF2);
    rd(A_CFG, d); check("R2 cfg readback", d, 32'h2);
    wr(A_MODE, KEYV | 32'h0000_00A0);
    rd(A_MODE, d); check("R2 mode readback", d, 32'hA0);

    // R3 wrong key ignored
    wr(A_MODE, 32'h16AB_0051);
    rd(A_MODE, d); check("R3 mode kept", d, 32'hA0);
    wr(A_CFG, 32'h0000_0001);
    rd(A_CFG, d); check("R3 cfg kept", d, 32'h2);

    // R5 / R7 table of codes with reset action
    for (int v = 0; v < NV; v++) begin
      arm(4'(VEC[v][0]), 2'b01);
      ticks_to_rst(40, n);
      check($sformatf("R5 code %0d ticks", VEC[v][0]), n, VEC[v][1]);
    end

    // R7 one-cycle pulse, counter reloads after expiry
    arm(4'h1, 2'b01);
    pulse_tick(); check("R7 no early reset", {31'b0, sys_rst_o}, 0);
    pulse_tick(); check("R7 pulse high", {31'b0, sys_rst_o}, 1);
    @(negedge clk); check("R7 pulse one cycle", {31'b0, sys_rst_o}, 0);
    check("R7 no irq", {31'b0, irq_o}, 0);
    ticks_to_rst(10, n); check("R7 next interval full", n, 2);

    // R4 bad reloads ignored, good reload restores
    arm(4'h2, 2'b01);
    repeat (3) pulse_tick();
    wr(A_CTRL, 32'h0000_14AE);
    wr(A_CTRL, 32'h0000_14AD);
    wr(A_CFG, 32'h0000_14AF);
    ticks_to_rst(10, n); check("R4 bad reload ignored", n, 1);
    repeat (3) pulse_tick();
    wr(A_CTRL, RELOAD);
    ticks_to_rst(10, n); check("R4 good reload restores", n, 4);

    // R9 new code then reload
    arm(4'h3, 2'b01);
    repeat (2) pulse_tick();
    wr(A_MODE, KEYV | 32'h0000_0011);
    wr(A_CTRL, RELOAD);
    ticks_to_rst(10, n); check("R9 new interval", n, 2);

    // R6 keyed disable stops count
    arm(4'h0, 2'b01);
    wr(A_MODE, KEYV | 32'h0000_0000);
    ticks_to_rst(6, n); check("R6 disabled no reset", n, 0);
    check("R6 no irq", {31'b0, irq_o}, 0);

    // R8 interrupt action
    arm(4'h0, 2'b10);
    pulse_tick();
    check("R8 irq set", {31'b0, irq_o}, 1);
    check("R8 no reset", {31'b0, sys_rst_o}, 0);
    repeat (3) pulse_tick();
    wr(A_CTRL, 32'h0000_14AE);
    check("R8 irq sticky", {31'b0, irq_o}, 1);
    wr(A_MODE, KEYV | 32'h0000_0000);
    wr(A_CTRL, RELOAD);
    check("R8 irq cleared", {31'b0, irq_o}, 0);
    arm(4'h0, 2'b00);
    pulse_tick();
    check("R8 action 00 irq", {31'b0, irq_o}, 1);
    check("R8 action 00 no reset", {31'b0, sys_rst_o}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule